// File: doc/BRIEF.md
# Floating-Point Operand Unpacker and Classifier

This block takes one packed binary floating-point operand in single (32-bit), double (64-bit) or quad (128-bit) width and turns it into a common internal record. The record holds a sign, a class code, a signed unbiased exponent and a 128-bit significand. The significand is seen as four 32-bit words, and word 0 is the most significant. The record also carries rounding and sticky flags, which are always cleared. Every format uses the same layout. The hidden bit sits at bit 16 of word 0, which is flat bit 112. The fraction is left-aligned directly below the hidden bit. A NaN always comes out in quieted form, and a flag reports whether it was signaling.

A request is given by pulsing `start` while the block is idle. Zeros, normals, infinities and NaNs finish in one cycle. Subnormals are renormalized by a shifter that moves one bit per cycle, and the exponent is decremented on each shift. The `done` output pulses once when the record is valid. The outputs then hold until the next request is accepted. A separate combinational output remaps an operand register number for double and quad operands.

Top module: `fp_unpacker`

## Requirements
- R1: An exponent field of zero with an all-zero fraction gives class code 0 (zero). The input sign is kept, so negative zero stays negative. The significand and the exponent are all zeros.
- R2: A normal input gives class code 1. The exponent is the field value minus the bias (127, 1023 or 16383). Bit 112 is set. The fraction sits in bits 111:89 (single), 111:60 (double) or 111:0 (quad), and all lower bits are zero.
- R3: An all-ones exponent field (0xFF, 0x7FF or 0x7FFF) with a zero fraction gives class code 2 (infinity). The significand and the exponent are zero.
- R4: An all-ones exponent field with a nonzero fraction gives a NaN. The NaN is class code 3 (quiet) when the top fraction bit is 1, and class code 4 (signaling) when that bit is 0.
- R5: For a NaN, bits 112 and 111 of the significand are both set. The other fraction bits keep their aligned places. The exponent is zero.
- R6: The `invalid` output is 1 exactly when the result is a signaling NaN.
- R7: A subnormal input is loaded without a hidden bit at exponent 1-bias. It is shifted left k times until bit 112 is 1, and the exponent becomes 1-bias-k. It is reported as class 1.
- R8: Count rising edges starting with the accepting edge. `done` is high after 1 edge for a non-subnormal input, and after k+2 edges for a subnormal that needs k shifts. `done` is high for exactly one cycle.
- R9: `roundFlag` and `stickyFlag` are always 0.
- R10: `regOut` equals {1'b1, regIn[4:1], 1'b0} when the format is not single and regIn[0] is 1. Otherwise it equals {1'b0, regIn}.
- R11: `start` is ignored while `busy` is high. After `done`, the outputs keep their values until the next accepted `start`.
- R12: The format codes are 0 for single, 1 for double, and 2 or 3 for quad. The single operand is taken from opIn[31:0] and the double operand from opIn[63:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| fmt | input | 2 | Operand format code |
| opIn | input | 128 | Packed operand, right-aligned |
| regIn | input | 5 | Register number to remap |
| busy | output | 1 | High while a subnormal is being normalized |
| done | output | 1 | One-cycle result-valid strobe |
| signOut | output | 1 | Sign of the result |
| clsOut | output | 3 | Class code |
| expOut | output | 18 | Signed unbiased exponent |
| sigOut | output | 128 | Significand, word 0 in bits 127:96 |
| roundFlag | output | 1 | Rounding flag, always cleared |
| stickyFlag | output | 1 | Sticky flag, always cleared |
| invalid | output | 1 | Signaling-NaN flag |
| regOut | output | 6 | Remapped register number |

## Verification
The hardest state to reach is a long normalization that gets a second request in the middle of it. That case checks both the shift count and the rule that a busy block ignores `start`. The stimulus reaches it with a quad subnormal whose only set bit is bit 0. That operand needs 112 shifts. A single-precision `start` is pulsed a few cycles into the run. The final record and the edge count must still match the first operand. The sweeps also move a single set fraction bit through every position of every format, so that every shift count from 1 to the full fraction width is covered.

// File: rtl/fp_unpack_pkg.sv
package fp_unpack_pkg;
  typedef enum logic [2:0] {
    ClsZero   = 3'd0,
    ClsNormal = 3'd1,
    ClsInf    = 3'd2,
    ClsQnan   = 3'd3,
    ClsSnan   = 3'd4
  } cls_e;

  typedef enum logic [1:0] {
    FmtSingle  = 2'd0,
    FmtDouble  = 2'd1,
    FmtQuad    = 2'd2,
    FmtQuadAlt = 2'd3
  } fmt_e;

  typedef struct packed {
    logic load;
    logic shift;
  } strobe_t;
endpackage

// File: rtl/fp_unpack_dp.sv
module fp_unpack_dp
  import fp_unpack_pkg::*;
#(
  parameter int ExpW   = 18,
  parameter int WordW  = 32,
  parameter int Words  = 4,
  parameter int HidPos = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strb,
  input  logic [1:0]             fmt,
  input  logic [WordW*Words-1:0] opIn,
  output logic                   isSub,
  output logic                   leadSet,
  output logic                   signOut,
  output logic [2:0]             clsOut,
  output logic signed [ExpW-1:0] expOut,
  output logic [WordW*Words-1:0] sigOut,
  output logic                   invalid
);
  localparam int SigW   = WordW * Words;
  localparam int HidBit = SigW - WordW + HidPos;

  logic [14:0]            expF;
  logic                   allOnes, expZero, fracZero, nSign, nInv;
  logic [HidBit-1:0]      frac;
  logic signed [ExpW-1:0] biasV, nExp;
  logic [SigW-1:0]        nSig;
  cls_e                   nCls;

  always_comb begin
    case (fmt)
      FmtSingle: begin
        nSign   = opIn[31];
        expF    = {7'b0, opIn[30:23]};
        allOnes = &opIn[30:23];
        frac    = {opIn[22:0], {(HidBit-23){1'b0}}};
        biasV   = ExpW'(127);
      end
      FmtDouble: begin
        nSign   = opIn[63];
        expF    = {4'b0, opIn[62:52]};
        allOnes = &opIn[62:52];
        frac    = {opIn[51:0], {(HidBit-52){1'b0}}};
        biasV   = ExpW'(1023);
      end
      default: begin
        nSign   = opIn[127];
        expF    = opIn[126:112];
        allOnes = &opIn[126:112];
        frac    = opIn[HidBit-1:0];
        biasV   = ExpW'(16383);
      end
    endcase
    expZero  = (expF == '0);
    fracZero = (frac == '0);
    nSig = '0;
    nExp = '0;
    nInv = 1'b0;
    nCls = ClsNormal;
    if (expZero && fracZero) begin
      nCls = ClsZero;
    end else if (expZero) begin
      nSig = SigW'(frac);
      nExp = ExpW'(1) - biasV;
    end else if (allOnes && fracZero) begin
      nCls = ClsInf;
    end else if (allOnes) begin
      nCls = frac[HidBit-1] ? ClsQnan : ClsSnan;
      nInv = ~frac[HidBit-1];
      nSig = SigW'({2'b11, frac[HidBit-2:0]});
    end else begin
      nSig = SigW'({1'b1, frac});
      nExp = $signed(ExpW'(expF)) - biasV;
    end
  end

  assign isSub   = expZero && !fracZero;
  assign leadSet = sigOut[HidBit];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      signOut <= 1'b0;
      clsOut  <= ClsZero;
      expOut  <= '0;
      sigOut  <= '0;
      invalid <= 1'b0;
    end else if (strb.load) begin
      signOut <= nSign;
      clsOut  <= nCls;
      expOut  <= nExp;
      sigOut  <= nSig;
      invalid <= nInv;
    end else if (strb.shift) begin
      sigOut <= sigOut << 1;
      expOut <= expOut - ExpW'(1);
    end
  end

  // R7: the control never asks for a shift once the leading one is in place
  a_r7_shift_only_below: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |-> !leadSet);
endmodule

// File: rtl/fp_unpack_ctrl.sv
module fp_unpack_ctrl
  import fp_unpack_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    isSub,
  input  logic    leadSet,
  output strobe_t strb,
  output logic    busy,
  output logic    done
);
  typedef enum logic {SIdle, SNorm} state_e;
  state_e state;

  assign busy       = (state == SNorm);
  assign strb.load  = (state == SIdle) && start;
  assign strb.shift = (state == SNorm) && !leadSet;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= SIdle;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        SIdle: if (start) begin
          if (isSub) state <= SNorm;
          else       done  <= 1'b1;
        end
        default: if (leadSet) begin
          done  <= 1'b1;
          state <= SIdle;
        end
      endcase
    end
  end

  // R11: normalization only begins from an accepted request
  a_r11_busy_from_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));
  // R8: done is a single-cycle strobe
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done || $past(start));
endmodule

// File: rtl/fp_unpacker.sv
module fp_unpacker
  import fp_unpack_pkg::*;
#(
  parameter int ExpW = 18,
  parameter int RegW = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [1:0]             fmt,
  input  logic [127:0]           opIn,
  input  logic [RegW-1:0]        regIn,
  output logic                   busy,
  output logic                   done,
  output logic                   signOut,
  output logic [2:0]             clsOut,
  output logic signed [ExpW-1:0] expOut,
  output logic [127:0]           sigOut,
  output logic                   roundFlag,
  output logic                   stickyFlag,
  output logic                   invalid,
  output logic [RegW:0]          regOut
);
  strobe_t strb;
  logic    isSub, leadSet;

  fp_unpack_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .isSub(isSub), .leadSet(leadSet),
    .strb(strb), .busy(busy), .done(done)
  );

  fp_unpack_dp #(.ExpW(ExpW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fmt(fmt), .opIn(opIn),
    .isSub(isSub), .leadSet(leadSet), .signOut(signOut), .clsOut(clsOut),
    .expOut(expOut), .sigOut(sigOut), .invalid(invalid)
  );

  assign roundFlag  = 1'b0;
  assign stickyFlag = 1'b0;

  logic wideOp;
  assign wideOp = (fmt != FmtSingle);
  assign regOut = (wideOp && regIn[0]) ? {1'b1, regIn[RegW-1:1], 1'b0}
                                       : {1'b0, regIn};

  // R7: a finished normal result always carries its leading one at bit 112
  a_r7_done_normalized: assert property (@(posedge clk) disable iff (!rstN)
    (done && clsOut == ClsNormal) |-> sigOut[112]);
  // R6: the invalid flag tracks the signaling class
  a_r6_snan_flag: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (invalid == (clsOut == ClsSnan)));
  // R11: with no request and no normalization, the record holds
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(busy) && !$past(start)) |-> ($stable(sigOut) && $stable(expOut) && $stable(clsOut)));
endmodule

// File: tb/fp_unpacker_bench.sv
module fp_unpacker_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   fmt = 2'd0;
  logic [127:0] opIn = '0;
  logic [4:0]   regIn = '0;
  logic         busy, done, signOut, roundFlag, stickyFlag, invalid;
  logic [2:0]   clsOut;
  logic signed [17:0] expOut;
  logic [127:0] sigOut;
  logic [5:0]   regOut;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  fp_unpacker u_fp_unpacker (
    .clk(clk), .rstN(rstN), .start(start), .fmt(fmt), .opIn(opIn), .regIn(regIn),
    .busy(busy), .done(done), .signOut(signOut), .clsOut(clsOut), .expOut(expOut),
    .sigOut(sigOut), .roundFlag(roundFlag), .stickyFlag(stickyFlag),
    .invalid(invalid), .regOut(regOut)
  );

  always #4 clk = ~clk;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++; fails++;
      $display("FAIL R8 watchdog expired: actual %0d cycles, expected fewer", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input string detail);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", req, detail);
    end
  endtask

  function automatic void fmtInfo(input int f, output int ew, output int fw, output int bias);
    if (f == 0)      begin ew = 8;  fw = 23;  bias = 127;   end
    else if (f == 1) begin ew = 11; fw = 52;  bias = 1023;  end
    else             begin ew = 15; fw = 112; bias = 16383; end
  endfunction

  function automatic logic [127:0] mkOp(input int f, input bit s, input int e, input logic [111:0] fr);
    int ew, fw, bias;
    logic [127:0] one = 128'd1;
    fmtInfo(f, ew, fw, bias);
    return ({127'd0, s} << (ew + fw)) | (128'(e) << fw) | (128'(fr) & ((one << fw) - 1));
  endfunction

  // expected record computed from the requirements
  function automatic void model(input int f, input logic [127:0] op,
      output bit s, output logic [2:0] c, output logic signed [17:0] e,
      output logic [127:0] sg, output bit inv, output int lat, output string req);
    int ew, fw, bias, ef, p, k;
    logic [111:0] fr, fa;
    logic [127:0] one = 128'd1;
    fmtInfo(f, ew, fw, bias);
    s  = op[ew + fw];
    ef = int'((op >> fw) & ((one << ew) - 1));
    fr = 112'(op & ((one << fw) - 1));
    fa = fr << (112 - fw);
    sg = '0; e = '0; inv = 0; lat = 1;
    if (ef == 0 && fr == 0) begin
      c = 3'd0; req = "R1";
    end else if (ef == 0) begin
      p = 0;
      for (int i = 0; i < fw; i++) if (fr[i]) p = i;
      k = fw - p;
      sg = {16'd0, fa} << k;
      e = 18'(1 - bias - k);
      c = 3'd1; lat = k + 2; req = "R7";
    end else if (ef == (1 << ew) - 1 && fr == 0) begin
      c = 3'd2; req = "R3";
    end else if (ef == (1 << ew) - 1) begin
      c = fa[111] ? 3'd3 : 3'd4;
      inv = !fa[111];
      sg = {16'd0, fa} | (one << 112) | (one << 111);
      req = fa[111] ? "R5" : "R4";
    end else begin
      c = 3'd1;
      sg = {16'd0, fa} | (one << 112);
      e = 18'(ef - bias);
      req = "R2";
    end
  endfunction

  task automatic runOne(input int fcode, input logic [127:0] op);
    bit es, einv; logic [2:0] ec; logic signed [17:0] ee; logic [127:0] esg;
    int elat, n; string req;
    model(fcode >= 2 ? 2 : fcode, op, es, ec, ee, esg, einv, elat, req);
    @(negedge clk);
    fmt = 2'(fcode); opIn = op; start = 1'b1; n = 0;
    do begin
      @(posedge clk); #1; start = 1'b0; n++;
    end while (!done && n < 300);
    chk(signOut == es && clsOut == ec && expOut == ee && sigOut == esg, req,
        $sformatf("fmt %0d op %h: actual s%0d c%0d e%0d sig %h, expected s%0d c%0d e%0d sig %h",
                  fcode, op, signOut, clsOut, expOut, sigOut, es, ec, ee, esg));
    chk(invalid == einv, "R6", $sformatf("op %h: actual invalid %0d, expected %0d", op, invalid, einv));
    chk(n == elat, "R8", $sformatf("op %h: actual latency %0d, expected %0d", op, n, elat));
    chk(!roundFlag && !stickyFlag, "R9", $sformatf("actual round %0d sticky %0d, expected 0 0", roundFlag, stickyFlag));
  endtask

  initial begin
    logic [127:0] holdSig;
    logic signed [17:0] holdExp;
    logic [111:0] pat;
    int ew, fw, bias, n;
    int exps[5];
    repeat (3) @(posedge clk);
    #1;
    chk(!done && !busy && clsOut == 3'd0 && sigOut == '0 && !invalid, "R1",
        $sformatf("reset: actual done %0d busy %0d cls %0d, expected 0 0 0", done, busy, clsOut));
    @(negedge clk); rstN = 1'b1;

    // R1-style sweep across all formats, signs, exponent corners and fraction bits
    for (int f = 0; f < 3; f++) begin
      fmtInfo(f, ew, fw, bias);
      exps = '{0, 1, bias, (1 << ew) - 2, (1 << ew) - 1};
      for (int s = 0; s < 2; s++)
        for (int ei = 0; ei < 5; ei++) begin
          runOne(f, mkOp(f, s[0], exps[ei], '0));
          runOne(f, mkOp(f, s[0], exps[ei], '1));
          runOne(f, mkOp(f, s[0], exps[ei], {28{4'hA}}));
          runOne(f, mkOp(f, s[0], exps[ei], {28{4'h5}}));
          for (int b = 0; b < fw; b++) begin
            pat = '0; pat[b] = 1'b1;
            runOne(f, mkOp(f, s[0], exps[ei], pat));
          end
        end
    end

    // R12: format code 3 also selects quad
    runOne(3, mkOp(2, 1'b0, 16383, 112'h1234));
    runOne(3, mkOp(2, 1'b1, 0, 112'h8));

    // R11: a start during a long normalization is ignored, then the result holds
    @(negedge clk);
    fmt = 2'd2; opIn = mkOp(2, 1'b0, 0, 112'd1); start = 1'b1; n = 0;
    do begin
      @(posedge clk); #1; start = 1'b0; n++;
      if (n == 5) begin
        @(negedge clk); fmt = 2'd0; opIn = mkOp(0, 1'b1, 127, 112'd0); start = 1'b1;
      end
    end while (!done && n < 300);
    chk(n == 114, "R11", $sformatf("busy start: actual latency %0d, expected 114", n));
    chk(sigOut == (128'd1 << 112) && expOut == 18'(1 - 16383 - 112) && !signOut, "R11",
        $sformatf("busy start: actual sig %h exp %0d, expected bit112 exp %0d", sigOut, expOut, 1 - 16383 - 112));
    holdSig = sigOut; holdExp = expOut;
    repeat (4) @(posedge clk);
    #1;
    chk(!done && sigOut == holdSig && expOut == holdExp, "R11",
        $sformatf("hold: actual done %0d sig %h, expected 0 %h", done, sigOut, holdSig));

    // R10: register remap over every register number and format
    for (int f = 0; f < 4; f++)
      for (int r = 0; r < 32; r++) begin
        logic [5:0] exp6;
        fmt = 2'(f); regIn = 5'(r);
        #1;
        exp6 = (f != 0 && r[0]) ? 6'((r & 'h1E) | 'h20) : 6'(r);
        chk(regOut == exp6, "R10", $sformatf("fmt %0d reg %0d: actual %0d, expected %0d", f, r, regOut, exp6));
      end

    finish_run();
  end
endmodule